// File: doc/BRIEF.md
# Single-Cycle Ten-Instruction Processor Core

This core runs a small 32-bit load/store instruction set and retires one instruction on every rising clock edge. Within one cycle it fetches from an instruction port, reads two operands from a 32-word register file, runs the ALU, optionally touches a data port, and writes the result back. The next program counter is formed in the same cycle from one of three sources: the sequential PC+4 adder, a dedicated branch-target adder, or the jump-target concatenation.

Both memories are outside the core and are read combinationally. The instruction port shows the current PC, and the instruction word comes back in the same cycle. The data port shows an address, write data and a write strobe, and load data returns in the same cycle. Two flags report trouble. One marks a word the core does not decode. The other marks signed overflow of an R-type add or subtract. In both cases the architectural writes of that instruction are withheld.

Top module: `mono_cycle_core`

## Requirements
- R1: While `rst` is high at a rising edge, the PC and every register are cleared to zero, so `imem_addr` reads 0 in the first cycle after reset.
- R2: Every instruction other than a taken branch or a jump, including undecodable ones, moves the PC to PC+4 at the end of its cycle.
- R3: With opcode 000000, funct selects the operation: 32 add, 34 sub, 36 and, 37 or, 39 nor, 42 signed set-less-than. The operands come from rs [25:21] and rt [20:16]. The result is written to rd [15:11] at the edge that ends the cycle, and the next instruction can read it.
- R4: Opcode 100011 (load) drives `dmem_addr` with rs plus the sign-extended bits [15:0], and writes `dmem_rdata` into rt.
- R5: Opcode 101011 (store) raises `dmem_we`, drives the same address form, drives `dmem_wdata` with rt, and changes no register. `dmem_we` is low for every other instruction.
- R6: Opcode 000100 (branch-if-equal) sets the next PC to PC+4+4×sext(bits [15:0]) when rs equals rt, and to PC+4 otherwise.
- R7: Opcode 000010 (jump) sets the next PC to {PC+4 bits [31:28], bits [25:0], 2'b00}.
- R8: Register 0 always reads zero, and writes to it have no effect.
- R9: Any other opcode, or opcode 000000 with a funct outside the R3 list, raises `illegal_instr` in that cycle and suppresses both the register write and the memory write.
- R10: When an R-type add or sub overflows as a signed 32-bit operation, `overflow` is high for that cycle and the register write is suppressed. No other instruction raises it, including the address add and the branch compare.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state updates on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| imem_addr | output | 32 | Address of the current instruction (the PC) |
| imem_rdata | input | 32 | Instruction word at `imem_addr` |
| dmem_addr | output | 32 | Data address from the ALU |
| dmem_wdata | output | 32 | Store data (rt contents) |
| dmem_we | output | 1 | Data write strobe for a store |
| dmem_rdata | input | 32 | Load data at `dmem_addr` |
| illegal_instr | output | 1 | Current word is not decodable |
| overflow | output | 1 | Current add/sub overflowed in signed arithmetic |

## Verification
Overflow with its suppressed writeback is the hardest case to reach from the ports. Registers clear at reset, and random ALU traffic on small values seldom crosses the signed limit. The bench therefore preloads data memory with 0x7FFFFFFF and 0x80000000, loads them into registers, and issues add and sub on them. It then stores the destination to expose the value left in place. Random traffic continues from random memory contents with loads frequent, so large operands keep reappearing. A final sweep stores every register so that results can be compared with the bench's own model.

// File: rtl/sc_pkg.sv
package sc_pkg;
  localparam int XLEN   = 32;
  localparam int REG_N  = 32;
  localparam int REG_AW = $clog2(REG_N);

  localparam logic [5:0] OP_RTYPE = 6'h00;
  localparam logic [5:0] OP_JMP   = 6'h02;
  localparam logic [5:0] OP_BEQ   = 6'h04;
  localparam logic [5:0] OP_LOAD  = 6'h23;
  localparam logic [5:0] OP_STORE = 6'h2B;

  localparam logic [5:0] FN_ADD = 6'd32;
  localparam logic [5:0] FN_SUB = 6'd34;
  localparam logic [5:0] FN_AND = 6'd36;
  localparam logic [5:0] FN_OR  = 6'd37;
  localparam logic [5:0] FN_NOR = 6'd39;
  localparam logic [5:0] FN_SLT = 6'd42;

  typedef enum logic [2:0] {
    ALU_AND, ALU_OR, ALU_ADD, ALU_SUB, ALU_SLT, ALU_NOR
  } alu_op_e;

  typedef struct packed {
    logic dst_rd;   // destination from rd instead of rt
    logic src_imm;  // second operand is sign-extended immediate
    logic wb_mem;   // writeback from data port
    logic reg_wr;
    logic mem_wr;
    logic branch;
    logic jump;
    logic illegal;
    logic ovf_chk;  // overflow is architecturally visible
  } ctl_t;

  function automatic logic [XLEN-1:0] sext16(input logic [15:0] v);
    return {{(XLEN-16){v[15]}}, v};
  endfunction

  function automatic logic [XLEN-1:0] branch_dest(input logic [XLEN-1:0] pc4,
                                                  input logic [15:0] off);
    return pc4 + (sext16(off) << 2);
  endfunction

  function automatic logic [XLEN-1:0] jump_dest(input logic [XLEN-1:0] pc4,
                                                input logic [25:0] tgt);
    return {pc4[XLEN-1:XLEN-4], tgt, 2'b00};
  endfunction

  function automatic logic add_ovf(input logic [XLEN-1:0] a, b, s);
    return (a[XLEN-1] == b[XLEN-1]) && (s[XLEN-1] != a[XLEN-1]);
  endfunction

  function automatic logic sub_ovf(input logic [XLEN-1:0] a, b, d);
    return (a[XLEN-1] != b[XLEN-1]) && (d[XLEN-1] != a[XLEN-1]);
  endfunction
endpackage

// File: rtl/sc_decode.sv
module sc_decode
  import sc_pkg::*;
(
  input  logic [5:0] opcode,
  input  logic [5:0] funct,
  output ctl_t       ctl,
  output alu_op_e    alu_op
);
  always_comb begin
    ctl    = '0;
    alu_op = ALU_ADD;
    unique case (opcode)
      OP_RTYPE: begin
        ctl.dst_rd = 1'b1;
        ctl.reg_wr = 1'b1;
        unique case (funct)
          FN_ADD: begin alu_op = ALU_ADD; ctl.ovf_chk = 1'b1; end
          FN_SUB: begin alu_op = ALU_SUB; ctl.ovf_chk = 1'b1; end
          FN_AND: alu_op = ALU_AND;
          FN_OR:  alu_op = ALU_OR;
          FN_NOR: alu_op = ALU_NOR;
          FN_SLT: alu_op = ALU_SLT;
          default: begin
            ctl.illegal = 1'b1;
            ctl.reg_wr  = 1'b0;
          end
        endcase
      end
      OP_LOAD: begin
        ctl.src_imm = 1'b1;
        ctl.wb_mem  = 1'b1;
        ctl.reg_wr  = 1'b1;
      end
      OP_STORE: begin
        ctl.src_imm = 1'b1;
        ctl.mem_wr  = 1'b1;
      end
      OP_BEQ: begin
        ctl.branch = 1'b1;
        alu_op     = ALU_SUB;
      end
      OP_JMP:  ctl.jump    = 1'b1;
      default: ctl.illegal = 1'b1;
    endcase
  end

  // R9: an undecodable word never carries a write request out of decode
  always_comb begin
    if (ctl.illegal) begin
      p_illegal_no_req_r9: assert (!ctl.reg_wr && !ctl.mem_wr);
    end
  end
endmodule

// File: rtl/sc_alu.sv
module sc_alu
  import sc_pkg::*;
#(
  parameter int W = XLEN
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  alu_op_e      op,
  output logic [W-1:0] y,
  output logic         zero,
  output logic         ovf
);
  logic [W-1:0] sum, diff;
  assign sum  = a + b;
  assign diff = a - b;

  always_comb begin
    ovf = 1'b0;
    unique case (op)
      ALU_AND: y = a & b;
      ALU_OR:  y = a | b;
      ALU_NOR: y = ~(a | b);
      ALU_ADD: begin y = sum;  ovf = add_ovf(a, b, sum);  end
      ALU_SUB: begin y = diff; ovf = sub_ovf(a, b, diff); end
      ALU_SLT: y = {{(W-1){1'b0}}, ($signed(a) < $signed(b))};
      default: y = sum;
    endcase
  end

  assign zero = (y == '0);
endmodule

// File: rtl/sc_regfile.sv
module sc_regfile #(
  parameter int W  = 32,
  parameter int N  = 32,
  localparam int AW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr_a,
  input  logic [AW-1:0] raddr_b,
  output logic [W-1:0]  rdata_a,
  output logic [W-1:0]  rdata_b
);
  logic [W-1:0] regs [N];

  for (genvar i = 0; i < N; i++) begin : g_reg
    if (i == 0) begin : g_hard_zero
      assign regs[i] = '0;
    end else begin : g_word
      always_ff @(posedge clk) begin
        if (rst)                                   regs[i] <= '0;
        else if (we && waddr == AW'(i))            regs[i] <= wdata;
      end
    end
  end

  assign rdata_a = regs[raddr_a];
  assign rdata_b = regs[raddr_b];

  // R8: a port addressing register 0 returns zero in the cycle after any write
  p_r0_reads_zero_r8: assert property (@(posedge clk) disable iff (rst)
    (we && waddr == '0) |=> (regs[0] == '0));
endmodule

// File: rtl/mono_cycle_core.sv
module mono_cycle_core
  import sc_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  output logic [31:0] imem_addr,
  input  logic [31:0] imem_rdata,
  output logic [31:0] dmem_addr,
  output logic [31:0] dmem_wdata,
  output logic        dmem_we,
  input  logic [31:0] dmem_rdata,
  output logic        illegal_instr,
  output logic        overflow
);
  logic [XLEN-1:0] pc_q, pc_next, pc_plus4, br_tgt, jmp_tgt;
  logic [XLEN-1:0] rs_val, rt_val, alu_b, alu_y, wb_val, imm_x;
  logic [REG_AW-1:0] dest;
  logic        alu_zero, alu_ovf, rf_we;
  logic        take_branch, take_jump, seq_step;
  ctl_t        ctl;
  alu_op_e     alu_op;

  wire [5:0]  f_op   = imem_rdata[31:26];
  wire [4:0]  f_rs   = imem_rdata[25:21];
  wire [4:0]  f_rt   = imem_rdata[20:16];
  wire [4:0]  f_rd   = imem_rdata[15:11];
  wire [15:0] f_imm  = imem_rdata[15:0];
  wire [5:0]  f_fn   = imem_rdata[5:0];
  wire [25:0] f_tgt  = imem_rdata[25:0];

  sc_decode u_dec (
    .opcode (f_op),
    .funct  (f_fn),
    .ctl    (ctl),
    .alu_op (alu_op)
  );

  sc_regfile #(.W(XLEN), .N(REG_N)) u_rf (
    .clk     (clk),
    .rst     (rst),
    .we      (rf_we),
    .waddr   (dest),
    .wdata   (wb_val),
    .raddr_a (f_rs),
    .raddr_b (f_rt),
    .rdata_a (rs_val),
    .rdata_b (rt_val)
  );

  assign imm_x = sext16(f_imm);
  assign alu_b = ctl.src_imm ? imm_x : rt_val;

  sc_alu #(.W(XLEN)) u_alu (
    .a    (rs_val),
    .b    (alu_b),
    .op   (alu_op),
    .y    (alu_y),
    .zero (alu_zero),
    .ovf  (alu_ovf)
  );

  // writeback
  assign overflow      = ctl.ovf_chk & alu_ovf;
  assign illegal_instr = ctl.illegal;
  assign rf_we         = ctl.reg_wr & ~overflow;
  assign dest          = ctl.dst_rd ? f_rd : f_rt;
  assign wb_val        = ctl.wb_mem ? dmem_rdata : alu_y;

  // data port
  assign dmem_addr  = alu_y;
  assign dmem_wdata = rt_val;
  assign dmem_we    = ctl.mem_wr;

  // next PC
  assign pc_plus4    = pc_q + XLEN'(4);
  assign br_tgt      = branch_dest(pc_plus4, f_imm);
  assign jmp_tgt     = jump_dest(pc_plus4, f_tgt);
  assign take_branch = ctl.branch & alu_zero;
  assign take_jump   = ctl.jump;
  assign seq_step    = ~take_branch & ~take_jump;

  always_comb begin
    if (take_jump)        pc_next = jmp_tgt;
    else if (take_branch) pc_next = br_tgt;
    else                  pc_next = pc_plus4;
  end

  always_ff @(posedge clk) begin
    if (rst) pc_q <= '0;
    else     pc_q <= pc_next;
  end

  assign imem_addr = pc_q;

  // R1: PC is zero in the cycle after reset
  p_reset_pc_r1: assert property (@(posedge clk)
    $past(rst) |-> (pc_q == '0));

  // R2: sequential step advances by one word
  p_seq_pc_r2: assert property (@(posedge clk) disable iff (rst)
    seq_step |=> (pc_q == $past(pc_q) + 32'd4));

  // R6: taken branch lands on PC+4 plus scaled offset
  p_branch_pc_r6: assert property (@(posedge clk) disable iff (rst)
    take_branch |=> (pc_q == $past(pc_q) + 32'd4 + ($past(imm_x) << 2)));

  // R7: jump keeps the upper nibble of PC+4
  p_jump_pc_r7: assert property (@(posedge clk) disable iff (rst)
    take_jump |=> (pc_q[31:28] == $past(pc_plus4[31:28]) && pc_q[1:0] == 2'b00));

  // R9: no architectural write on an undecodable word
  p_illegal_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    illegal_instr |-> (!dmem_we && !rf_we));

  // R10: overflow blocks writeback and only arises on R-type
  p_no_overflow_write_r10: assert property (@(posedge clk) disable iff (rst)
    overflow |-> (!rf_we && f_op == OP_RTYPE));
endmodule

// File: tb/tb_mono_cycle_core.sv
module tb_mono_cycle_core;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] imem_addr, imem_rdata, dmem_addr, dmem_wdata, dmem_rdata;
  logic        dmem_we, illegal_instr, overflow;

  always #10 clk = ~clk;

  mono_cycle_core dut (
    .clk(clk), .rst(rst),
    .imem_addr(imem_addr), .imem_rdata(imem_rdata),
    .dmem_addr(dmem_addr), .dmem_wdata(dmem_wdata), .dmem_we(dmem_we),
    .dmem_rdata(dmem_rdata),
    .illegal_instr(illegal_instr), .overflow(overflow)
  );

  // bench-side data memory, 64 words, word index from address bits [7:2]
  logic [31:0] bmem [64];
  assign dmem_rdata = bmem[dmem_addr[7:2]];
  always @(posedge clk) if (dmem_we) bmem[dmem_addr[7:2]] <= dmem_wdata;

  // reference state
  logic [31:0] m_reg [32];
  logic [31:0] m_mem [64];
  logic [31:0] m_pc;
  string       pc_tag;
  int          n_run = 0, n_fail = 0;
  bit          done = 1'b0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] enc_r(input logic [5:0] fn, input logic [4:0] s, t, d);
    return {6'h00, s, t, d, 5'd0, fn};
  endfunction
  function automatic logic [31:0] enc_i(input logic [5:0] op, input logic [4:0] s, t,
                                        input logic [15:0] im);
    return {op, s, t, im};
  endfunction

  function automatic bit known_fn(input logic [5:0] f);
    return f == 6'd32 || f == 6'd34 || f == 6'd36 || f == 6'd37 || f == 6'd39 || f == 6'd42;
  endfunction
  function automatic bit known_op(input logic [5:0] o);
    return o == 6'h00 || o == 6'h02 || o == 6'h04 || o == 6'h23 || o == 6'h2B;
  endfunction

  // one instruction: drive, compare ports with the model, advance the model
  task automatic step(input logic [31:0] ins, input string st_tag);
    logic [5:0]  op = ins[31:26];
    logic [5:0]  fn = ins[5:0];
    logic [4:0]  s = ins[25:21], t = ins[20:16], d = ins[15:11];
    logic [31:0] sx = {{16{ins[15]}}, ins[15:0]};
    logic [31:0] a, b, r, addr, npc, pc4;
    logic [4:0]  dst = 5'd0;
    bit ill = 0, ovf = 0, wr = 0, we = 0, is_ld = 0;
    imem_rdata = ins;
    #5;
    a = m_reg[s]; b = m_reg[t]; pc4 = m_pc + 32'd4; npc = pc4;
    r = 32'd0; addr = a + sx;
    case (op)
      6'h00: begin
        dst = d; wr = 1;
        case (fn)
          6'd32: begin r = a + b; ovf = (a[31] == b[31]) && (r[31] != a[31]); end
          6'd34: begin r = a - b; ovf = (a[31] != b[31]) && (r[31] != a[31]); end
          6'd36: r = a & b;
          6'd37: r = a | b;
          6'd39: r = ~(a | b);
          6'd42: r = ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
          default: begin ill = 1; wr = 0; end
        endcase
        if (ovf) wr = 0;
      end
      6'h23: begin dst = t; wr = 1; is_ld = 1; r = m_mem[addr[7:2]]; end
      6'h2B: we = 1;
      6'h04: if (a == b) npc = pc4 + (sx << 2);
      6'h02: npc = {pc4[31:28], ins[25:0], 2'b00};
      default: ill = 1;
    endcase
    chk(imem_addr == m_pc, pc_tag, "pc", imem_addr, m_pc);
    chk(illegal_instr == ill, "R9", "illegal_instr", 32'(illegal_instr), 32'(ill));
    chk(overflow == ovf, "R10", "overflow", 32'(overflow), 32'(ovf));
    chk(dmem_we == we, ill ? "R9" : "R5", "dmem_we", 32'(dmem_we), 32'(we));
    if (we) begin
      chk(dmem_addr[7:2] == addr[7:2], "R5", "store address", dmem_addr, addr);
      chk(dmem_wdata == b, st_tag, "store data", dmem_wdata, b);
    end
    if (is_ld) chk(dmem_addr == addr, "R4", "load address", dmem_addr, addr);
    if (wr && dst != 5'd0) m_reg[dst] = r;
    if (we) m_mem[addr[7:2]] = b;
    pc_tag = (op == 6'h02) ? "R7" : (op == 6'h04) ? "R6" : "R2";
    m_pc = npc;
    @(negedge clk);
  endtask

  function automatic logic [31:0] gen();
    int k = int'($urandom % 100);
    logic [4:0] s = 5'($urandom), t = 5'($urandom), d = 5'($urandom);
    logic [5:0] x;
    logic [5:0] fns [6] = '{6'd32, 6'd34, 6'd36, 6'd37, 6'd39, 6'd42};
    if (k < 35) return enc_r(fns[$urandom % 6], s, t, d);
    if (k < 52) return enc_i(6'h23, s, t, 16'($urandom));
    if (k < 66) return enc_i(6'h2B, s, t, 16'($urandom));
    if (k < 76) return enc_i(6'h04, s, ($urandom % 2) ? s : t, 16'($signed($urandom % 17) - 8));
    if (k < 82) return {6'h02, 26'($urandom)};
    if (k < 91) begin
      do x = 6'($urandom); while (known_op(x));
      return {x, 26'($urandom)};
    end
    do x = 6'($urandom); while (known_fn(x));
    return enc_r(x, s, t, d);
  endfunction

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < 64; i++) begin
      m_mem[i] = $urandom;
      bmem[i]  = m_mem[i];
    end
    m_mem[1] = 32'h7FFF_FFFF; bmem[1] = 32'h7FFF_FFFF;
    m_mem[3] = 32'h8000_0000; bmem[3] = 32'h8000_0000;
    for (int i = 0; i < 32; i++) m_reg[i] = 32'd0;
    m_pc = 32'd0; pc_tag = "R1";
    imem_rdata = 32'd0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    // directed corners
    step(enc_i(6'h23, 5'd0, 5'd1, 16'd4), "R4");       // r1 = 0x7FFFFFFF
    step(enc_i(6'h23, 5'd0, 5'd3, 16'd12), "R4");      // r3 = 0x80000000
    step(enc_i(6'h2B, 5'd0, 5'd1, 16'd16), "R4");
    step(enc_r(6'd32, 5'd1, 5'd1, 5'd2), "R10");       // overflow, r2 stays 0
    step(enc_i(6'h2B, 5'd0, 5'd2, 16'd20), "R10");
    step(enc_r(6'd34, 5'd3, 5'd1, 5'd4), "R10");       // overflow on sub
    step(enc_i(6'h2B, 5'd0, 5'd4, 16'd24), "R10");
    step(enc_r(6'd32, 5'd1, 5'd3, 5'd5), "R3");        // 0xFFFFFFFF, no overflow
    step(enc_i(6'h2B, 5'd0, 5'd5, 16'd28), "R3");
    step(enc_r(6'd42, 5'd3, 5'd1, 5'd6), "R3");        // signed slt -> 1
    step(enc_i(6'h2B, 5'd0, 5'd6, 16'd32), "R3");
    step(enc_r(6'd39, 5'd1, 5'd0, 5'd7), "R3");        // nor -> 0x80000000
    step(enc_i(6'h2B, 5'd0, 5'd7, 16'd36), "R3");
    step(enc_r(6'd37, 5'd1, 5'd1, 5'd0), "R8");        // write to r0 ignored
    step(enc_i(6'h2B, 5'd0, 5'd0, 16'd40), "R8");
    step(enc_i(6'h04, 5'd0, 5'd0, 16'hFFFF), "R6");    // taken, back to itself
    step(enc_i(6'h04, 5'd1, 5'd3, 16'd5), "R6");       // not taken
    step({6'h02, 26'h123456}, "R7");
    step(enc_i(6'h3F, 5'd1, 5'd8, 16'd0), "R9");       // undefined opcode
    step(enc_r(6'h01, 5'd1, 5'd1, 5'd8), "R9");        // undefined funct
    step(enc_i(6'h2B, 5'd0, 5'd8, 16'd44), "R9");

    // random traffic
    for (int n = 0; n < 4000; n++) step(gen(), "R5");

    // expose every register through the store port
    for (int r = 1; r < 32; r++) step(enc_i(6'h2B, 5'd0, 5'(r), 16'(r * 4)), "R3");

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule